// File: doc/BRIEF.md
# Hiccup Overload Protection Sequencer

This block decides, for one regulator channel, whether the channel's power output is allowed to conduct and whether the overload status flag is raised. It watches a digital overload-detect input from the current comparator. It runs in one of two modes, chosen by a mode input.

In clamp mode the flag simply mirrors the overload input and the output stays on. In hiccup mode an overload switches the output off for a long rest window, measured in millisecond ticks. The output then comes back on for a short trial window. The flag stays raised for the whole of this cycle. The cycle repeats until a complete trial window sees no overload. The output then stays on and the flag drops.

While soft-start is still running, overload reports are ignored. Dropping the channel enable returns everything to the idle, off state. One instance is placed per output channel. It sits between the comparator and the gate-drive enable.

Top module: `olp_seq`

## Requirements
- R1: While `rst_n` is low or `chan_en` is low, the clock edge leaves `out_en` = 0 and `olf` = 0; the first edge with `chan_en` = 1 turns `out_en` on.
- R2: While `ss_done` = 0 the overload input is ignored: after each edge `out_en` = 1 and `olf` = 0.
- R3: In clamp mode (`dcl_mode` = 1, after soft-start) `out_en` stays 1 and `olf` equals the `ovl_det` value sampled at the previous edge.
- R4: In hiccup mode (`dcl_mode` = 0) with the output on and the flag low, an overload sampled at an edge turns `out_en` off and raises `olf` at that same edge.
- R5: The rest window ends on the `OFF_MS`-th `ms_tick` (default 900) counted from entry; at that edge `out_en` returns to 1 while `olf` stays 1.
- R6: The trial window ends on the `ON_MS`-th `ms_tick` (default 20). If `ovl_det` was high at any edge in the window, including the last one, the output goes off again for a new rest window.
- R7: A trial window that ends with no overload sampled leaves `out_en` = 1 and clears `olf` to 0.
- R8: Changing `dcl_mode` from 1 to 0 while `ovl_det` is high starts the rest window at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| ovl_det | input | 1 | Overload comparator result, 1 = overload |
| dcl_mode | input | 1 | 1 = clamp mode (flag follows overload), 0 = hiccup mode |
| chan_en | input | 1 | Channel enable |
| ss_done | input | 1 | Soft-start finished |
| out_en | output | 1 | Power output enable |
| olf | output | 1 | Overload status flag |

## Verification
The bench counts ticks to the exact edges where the rest window and the trial window close. An off-by-one window length would show up as an early or late change on `out_en`.

It pulses an overload for a single cycle at the start of a trial window and then clears it. A design that only looks at the overload on the final tick would wrongly resume.

It holds an overload during soft-start, which a design lacking the gating would turn into a spurious shutdown. It flips the mode bit with an overload present, which a design that waits for a fresh edge would miss. It also drops the enable in mid-rest, which must clear the flag rather than leave it stuck high.

// File: rtl/olp_seq.sv
module olp_seq #(
  parameter int OFF_MS = 900,
  parameter int ON_MS  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic ovl_det,
  input  logic dcl_mode,
  input  logic chan_en,
  input  logic ss_done,
  output logic out_en,
  output logic olf
);
  localparam int MAXW = (OFF_MS > ON_MS) ? OFF_MS : ON_MS;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_MS - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_REST, S_TRY} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          seen_nx;

  assign seen_nx = seen | ovl_det;
  assign out_en  = (st == S_RUN) || (st == S_TRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; seen <= 1'b0; olf <= 1'b0;
    end else if (!chan_en) begin
      st <= S_IDLE; cnt <= '0; seen <= 1'b0; olf <= 1'b0;
    end else if (!ss_done) begin
      st <= S_RUN; cnt <= '0; seen <= 1'b0; olf <= 1'b0;
    end else if (dcl_mode) begin
      st <= S_RUN; cnt <= '0; seen <= 1'b0; olf <= ovl_det;
    end else begin
      case (st)
        S_IDLE: begin
          st <= S_RUN; olf <= 1'b0;
        end
        S_RUN: begin
          cnt <= '0;
          if (ovl_det) begin
            st <= S_REST; olf <= 1'b1;
          end else begin
            olf <= 1'b0;
          end
        end
        S_REST: begin
          if (ms_tick) begin
            if (cnt == OFF_LAST) begin
              st <= S_TRY; cnt <= '0; seen <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (ms_tick && cnt == ON_LAST) begin
            cnt  <= '0;
            seen <= 1'b0;
            if (seen_nx) begin
              st <= S_REST;
            end else begin
              st <= S_RUN; olf <= 1'b0;
            end
          end else begin
            seen <= seen_nx;
            if (ms_tick) cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module olp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ovl_det,
  input logic dcl_mode,
  input logic chan_en,
  input logic ss_done,
  input logic out_en,
  input logic olf
);
  // R1
  disabled_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (!out_en && !olf));
  // R2
  softstart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !ss_done) |=> (out_en && !olf));
  // R3
  clamp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && dcl_mode) |=> (out_en && olf == $past(ovl_det)));
  // R4
  hiccup_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ss_done && !dcl_mode && out_en && !olf && ovl_det) |=> (!out_en && olf));
  // R7
  flag_clear_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(olf) |-> (out_en || !chan_en || !$past(chan_en)));
endmodule

bind olp_seq olp_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovl_det(ovl_det), .dcl_mode(dcl_mode),
  .chan_en(chan_en), .ss_done(ss_done), .out_en(out_en), .olf(olf)
);

// File: tb/olp_seq_tb.sv
module olp_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, ovl_det = 1'b0, dcl_mode = 1'b0, chan_en = 1'b0, ss_done = 1'b0;
  logic out_en, olf;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { bit oe; bit fl; string tag; } exp_t;
  exp_t q[$];
  event go;

  always #10 clk = ~clk;

  olp_seq u_dut (.clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ovl_det(ovl_det),
                 .dcl_mode(dcl_mode), .chan_en(chan_en), .ss_done(ss_done),
                 .out_en(out_en), .olf(olf));

  task automatic expect_now(input bit oe, input bit fl, input string tag);
    exp_t e;
    e.oe = oe; e.fl = fl; e.tag = tag;
    q.push_back(e);
    #1 -> go;
    #1;
  endtask

  initial begin
    forever begin
      @(go);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (out_en !== e.oe || olf !== e.fl) begin
          n_err++;
          $display("FAIL %s: out_en/olf = %b/%b, expected %b/%b", e.tag, out_en, olf, e.oe, e.fl);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  initial begin
    cyc(3);
    expect_now(0, 0, "R1 reset");
    rst_n = 1'b1;
    cyc(2);
    expect_now(0, 0, "R1 disabled after reset");
    chan_en = 1'b1;
    cyc(1);
    expect_now(1, 0, "R1 enable turns on");
    ovl_det = 1'b1;
    cyc(5);
    expect_now(1, 0, "R2 overload ignored in soft-start");
    ovl_det = 1'b0; ss_done = 1'b1;
    cyc(2);
    expect_now(1, 0, "R2 after soft-start");
    dcl_mode = 1'b1; ovl_det = 1'b1;
    cyc(1);
    expect_now(1, 1, "R3 clamp flag rises");
    ovl_det = 1'b0;
    cyc(1);
    expect_now(1, 0, "R3 clamp flag clears");
    ovl_det = 1'b1;
    cyc(1);
    expect_now(1, 1, "R3 clamp output stays on");
    dcl_mode = 1'b0;
    cyc(1);
    expect_now(0, 1, "R8 mode switch trips next edge");
    ovl_det = 1'b0;
    ticks(899);
    expect_now(0, 1, "R5 still resting after 899 ticks");
    ticks(1);
    expect_now(1, 1, "R5 trial starts on tick 900");
    ovl_det = 1'b1;
    ticks(19);
    expect_now(1, 1, "R6 trial window open");
    ticks(1);
    expect_now(0, 1, "R6 overload at end repeats rest");
    ovl_det = 1'b0;
    ticks(900);
    expect_now(1, 1, "R5 second trial");
    ticks(19);
    expect_now(1, 1, "R7 flag held in trial");
    ticks(1);
    expect_now(1, 0, "R7 clean trial resumes");
    cyc(3);
    expect_now(1, 0, "R7 stays running");
    ovl_det = 1'b1;
    cyc(1);
    expect_now(0, 1, "R4 hiccup trip");
    ovl_det = 1'b0;
    ticks(900);
    ovl_det = 1'b1;
    cyc(1);
    ovl_det = 1'b0;
    ticks(20);
    expect_now(0, 1, "R6 brief overload in trial restarts rest");
    ticks(300);
    chan_en = 1'b0;
    cyc(1);
    expect_now(0, 0, "R1 disable clears flag");
    chan_en = 1'b1;
    cyc(1);
    expect_now(1, 0, "R1 re-enable");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: done = 0, expected 1");
    end
    #5;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule